// File: doc/BRIEF.md
# Memory Block Search Unit

The block scans a stretch of memory for the first byte equal to a programmed key. Software writes the key, a base address and a length through a small write port. It then sets a start bit. A read channel fetches bytes one at a time from a synchronous memory. Each fetched byte lands in a capture register and is compared with the key. When the comparison hits, the read request is withheld and the scan halts.

No separate result register exists. The outcome is read from two places: the channel address, which points one past the matching byte, and a terminal-count flag, which is set only when the whole region was read without a hit.

The controller has four states:
- IDLE: waiting for start.
- FETCH: read strobe issued.
- LATCH: returned byte captured, address and count stepped.
- TEST: comparison evaluated.

The transitions are:
- IDLE to FETCH on an accepted start.
- FETCH to LATCH always.
- LATCH to TEST always.
- TEST to IDLE on a hit or on the final byte.
- TEST to FETCH otherwise.

Top module: `blk_search`

## Requirements
- R1: After reset, `busy`, `done`, `tc_status` and `mem_rd` are 0 and `chan_addr` is 0.
- R2: A write with `cfg_sel`=3 and `cfg_wdata[0]`=1 while not busy starts a scan. The start loads the channel address from the base register (`cfg_sel`=1) and clears `done` and `tc_status`. A start written while busy is ignored, and the running scan ends as if it had not been written.
- R3: Each byte takes three cycles. First `mem_rd` is high with `mem_addr` equal to `chan_addr`. Then the byte returned by the memory one cycle after the strobe is captured. Then the comparison is made. `chan_addr` increments by one in the capture cycle.
- R4: `mem_rd` is never high in two consecutive cycles, and bytes are read at ascending addresses.
- R5: When the captured byte equals the key (`cfg_sel`=0, `cfg_wdata[7:0]`), no further reads occur. `done` becomes 1, `tc_status` stays 0, and `chan_addr` equals the matching address plus one.
- R6: The length register (`cfg_sel`=2) takes `cfg_wdata[13:0]` as the byte count minus one, and upper bits are dropped. A scan reads at most that value plus one bytes.
- R7: If no byte of the region matches, the scan stops after its last byte with `done`=1, `tc_status`=1 and `chan_addr` equal to base plus the byte count.
- R8: A match on the last byte of the region is reported as found, with `tc_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 key, 1 base, 2 length, 3 control |
| cfg_wdata | input | 16 | Register write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| chan_addr | output | 16 | Current channel address |
| tc_status | output | 1 | Terminal count reached without a match |
| done | output | 1 | Scan finished |
| busy | output | 1 | Scan in progress |

## Verification
The assertions watch every cycle for the following:
- a single isolated read strobe;
- the address stepping by one two cycles after each strobe;
- start clearing the status;
- a hit in the test state ending the scan with no terminal count;
- no read while done.

Only the bench scenarios can show the rest:
- that the right byte is found;
- that the scan length follows the programmed count, including the truncated upper length bits;
- that a hit on the final byte wins;
- that a start issued mid-scan leaves the running search untouched.

These are checked against a behavioural model that is compared on every clock.

// File: rtl/bs_pkg.sv
package bs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LATCH = 2'd2,
        ST_TEST  = 2'd3
    } bs_state_e;

    localparam logic [1:0] SEL_KEY  = 2'd0;
    localparam logic [1:0] SEL_BASE = 2'd1;
    localparam logic [1:0] SEL_LEN  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;
endpackage

// File: rtl/bs_ctrl.sv
module bs_ctrl
    import bs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      hit,
    input  logic      last,
    output bs_state_e state,
    output logic      load,
    output logic      fetch,
    output logic      latch,
    output logic      done,
    output logic      tc
);
    bs_state_e nxt;

    // state register and sticky outcome flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            tc    <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                done <= 1'b0;
                tc   <= 1'b0;
            end else if (state == ST_TEST && (hit || last)) begin
                done <= 1'b1;
                tc   <= !hit;   // a hit on the final byte wins
            end
        end
    end

    // next state and strobes
    always_comb begin
        nxt   = state;
        load  = 1'b0;
        fetch = 1'b0;
        latch = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    nxt  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                fetch = 1'b1;
                nxt   = ST_LATCH;
            end
            ST_LATCH: begin
                latch = 1'b1;
                nxt   = ST_TEST;
            end
            ST_TEST: begin
                if (hit || last) nxt = ST_IDLE;
                else             nxt = ST_FETCH;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bs_channel.sv
module bs_channel #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  len,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            cnt  <= '0;
            last <= 1'b0;
        end else if (load) begin
            addr <= base;
            cnt  <= len;
            last <= 1'b0;
        end else if (step) begin
            addr <= addr + 1'b1;
            cnt  <= cnt - 1'b1;
            last <= (cnt == '0);
        end
    end
endmodule

// File: rtl/bs_compare.sv
module bs_compare #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] key,
    output logic              hit
);
    logic [DATA_W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       rx_q <= '0;
        else if (capture) rx_q <= rdata;
    end

    assign hit = (rx_q == key);
endmodule

// File: rtl/blk_search.sv
module blk_search
    import bs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] chan_addr,
    output logic              tc_status,
    output logic              done,
    output logic              busy
);
    logic [DATA_W-1:0] key_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  len_q;
    logic              start_pulse;
    logic              hit;
    logic              last;
    logic              load;
    logic              fetch;
    logic              latch;
    bs_state_e         state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            base_q <= '0;
            len_q  <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_KEY:  key_q  <= cfg_wdata[DATA_W-1:0];
                SEL_BASE: base_q <= cfg_wdata;
                SEL_LEN:  len_q  <= cfg_wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    assign start_pulse = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0];

    bs_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_pulse),
        .hit   (hit),
        .last  (last),
        .state (state),
        .load  (load),
        .fetch (fetch),
        .latch (latch),
        .done  (done),
        .tc    (tc_status)
    );

    bs_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (latch),
        .base  (base_q),
        .len   (len_q),
        .addr  (chan_addr),
        .last  (last)
    );

    bs_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (latch),
        .rdata   (mem_rdata),
        .key     (key_q),
        .hit     (hit)
    );

    assign mem_rd   = fetch;
    assign mem_addr = chan_addr;
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              tc,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] chan_addr,
    input logic              in_test,
    input logic              hit
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !tc)); // R2

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ##1 (chan_addr == $past(mem_addr, 2) + 1'b1)); // R3

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R4

    AST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && hit) |=> (done && !tc && !busy)); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_rd && !busy)); // R5

    AST_TC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> done); // R7
endmodule

bind blk_search bs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_pulse),
    .busy      (busy),
    .done      (done),
    .tc        (tc_status),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .chan_addr (chan_addr),
    .in_test   (state == bs_pkg::ST_TEST),
    .hit       (hit)
);

// File: tb/blk_search_tb.sv
`timescale 1ns/1ps
module blk_search_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'd0;
    logic [15:0] chan_addr;
    logic        tc_status, done, busy;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    bit fin = 1'b0;
    logic [7:0] mem [0:1023];

    // behavioural reference state
    int          m_ph = 0;
    int          m_rem = 0;
    logic [15:0] m_addr = 16'd0, m_base = 16'd0;
    logic [13:0] m_len = 14'd0;
    logic [7:0]  m_key = 8'd0, m_rx = 8'd0;
    logic        m_done = 1'b0, m_tc = 1'b0;

    always #2.5 clk = ~clk;

    blk_search u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .chan_addr(chan_addr), .tc_status(tc_status),
        .done(done), .busy(busy)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    always @(posedge clk) if (mem_rd) rd_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_addr = 0; m_base = 0; m_len = 0; m_key = 0;
            m_rx = 0; m_done = 0; m_tc = 0; m_rem = 0;
        end else begin
            case (m_ph)
                0: if (cfg_we && cfg_sel == 2'd3 && cfg_wdata[0]) begin
                       m_addr = m_base; m_rem = int'(m_len) + 1;
                       m_done = 0; m_tc = 0; m_ph = 1;
                   end
                1: m_ph = 2;
                2: begin
                       m_rx = mem[m_addr[9:0]];
                       m_addr = m_addr + 16'd1; m_rem = m_rem - 1; m_ph = 3;
                   end
                default: begin
                       if (m_rx == m_key) begin m_done = 1; m_ph = 0; end
                       else if (m_rem == 0) begin m_done = 1; m_tc = 1; m_ph = 0; end
                       else m_ph = 1;
                   end
            endcase
            if (cfg_we) begin
                if (cfg_sel == 2'd0) m_key = cfg_wdata[7:0];
                if (cfg_sel == 2'd1) m_base = cfg_wdata;
                if (cfg_sel == 2'd2) m_len = cfg_wdata[13:0];
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R4 mem_rd", {31'd0, mem_rd}, {31'd0, m_ph == 1});
            if (mem_rd) chk("R3 mem_addr", {16'd0, mem_addr}, {16'd0, m_addr});
            chk("R3 chan_addr", {16'd0, chan_addr}, {16'd0, m_addr});
            chk("R2 busy", {31'd0, busy}, {31'd0, m_ph != 0});
            chk("R5 done", {31'd0, done}, {31'd0, m_done});
            chk("R7 tc_status", {31'd0, tc_status}, {31'd0, m_tc});
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic launch(input logic [15:0] base, input logic [15:0] len, input logic [7:0] key);
        wr(2'd0, {8'd0, key});
        wr(2'd1, base);
        wr(2'd2, len);
        rd_cnt = 0;
        wr(2'd3, 16'd1);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
        mem[10'h103] = 8'hA1;
        mem[10'h203] = 8'hA2;
        mem[10'h300] = 8'hA3;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 tc", {31'd0, tc_status}, 32'd0);
        chk("R1 mem_rd", {31'd0, mem_rd}, 32'd0);
        chk("R1 chan_addr", {16'd0, chan_addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 match in the middle of the region
        launch(16'h0100, 16'd7, 8'hA1);
        chk("R2 busy after start", {31'd0, busy}, 32'd1);
        wait_done();
        chk("R5 addr after hit", {16'd0, chan_addr}, 32'h0104);
        chk("R5 tc after hit", {31'd0, tc_status}, 32'd0);
        chk("R5 reads", rd_cnt, 32'd4);
        repeat (4) @(negedge clk);
        chk("R5 no reads after hit", rd_cnt, 32'd4);

        // R7 no match
        launch(16'h0080, 16'd4, 8'h11);
        chk("R2 done cleared", {31'd0, done}, 32'd0);
        wait_done();
        chk("R7 tc", {31'd0, tc_status}, 32'd1);
        chk("R7 addr", {16'd0, chan_addr}, 32'h0085);
        chk("R6 reads", rd_cnt, 32'd5);

        // R8 match on the last byte
        launch(16'h0200, 16'd3, 8'hA2);
        wait_done();
        chk("R8 tc", {31'd0, tc_status}, 32'd0);
        chk("R8 addr", {16'd0, chan_addr}, 32'h0204);

        // R6 single-byte region
        launch(16'h0050, 16'd0, 8'h11);
        wait_done();
        chk("R6 one byte reads", rd_cnt, 32'd1);
        chk("R6 one byte addr", {16'd0, chan_addr}, 32'h0051);
        chk("R6 one byte tc", {31'd0, tc_status}, 32'd1);

        // R5 match on the first byte
        launch(16'h0300, 16'd9, 8'hA3);
        wait_done();
        chk("R5 first byte addr", {16'd0, chan_addr}, 32'h0301);
        chk("R5 first byte reads", rd_cnt, 32'd1);

        // R6 upper length bits dropped
        launch(16'h0010, 16'hC002, 8'h11);
        wait_done();
        chk("R6 truncated length reads", rd_cnt, 32'd3);
        chk("R6 truncated length addr", {16'd0, chan_addr}, 32'h0013);

        // R2 start while busy is ignored
        launch(16'h0040, 16'd9, 8'h11);
        repeat (7) @(negedge clk);
        wr(2'd1, 16'h0300);
        wr(2'd3, 16'd1);
        wait_done();
        chk("R2 ignored start addr", {16'd0, chan_addr}, 32'h004A);
        chk("R2 ignored start reads", rd_cnt, 32'd10);
        chk("R2 ignored start tc", {31'd0, tc_status}, 32'd1);

        repeat (3) @(negedge clk);
        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule